// File: doc/BRIEF.md
# Optical Port Line Conditioner

This block sits between an infrared transmit LED driver, an infrared photodetector input, and the logic behind them. On the transmit side a two-bit source select picks one of four signals to drive the optical transmit pin. The candidates are the serial data from a UART, a general-purpose output bit, an active-energy pulse and a reactive-energy pulse. The chosen signal can be inverted. It can also be gated with a free-running carrier of about 38 kHz, derived from the system clock, whose low time per period is one of four power-of-two fractions.

The carrier is applied only while the selected data sits at its active (low) level. A brownout indication from the power monitor removes the carrier, so the pin then follows the data directly.

On the receive side the optical input pin is first synchronised to the clock. It then feeds the UART receive line, optionally inverted. When the receive function is disabled, the pin is handed out as a general-purpose input and the UART line rests at its idle level.

Top module: `optx_port`

## Requirements
- R1: With modulation off, `tx_pin` one clock later equals the source chosen by `tx_sel`: 0 selects `uart_txd`, 1 selects `gpo_bit`, 2 selects `wh_pulse`, 3 selects `varh_pulse`.
- R2: When `tx_inv` is 1 the selected source is inverted. The inversion is applied before any modulation, so the inverted level is the one tested for the active state.
- R3: The carrier period is round(CLK_HZ / CARRIER_HZ) clock cycles. The phase counter starts at 0 on the first clock after reset and wraps at the end of each period.
- R4: The low part of each carrier period lies at the start of the period and lasts P>>1, P>>2, P>>3 or P>>4 cycles, for `duty_sel` values 1, 2, 3 and 0 respectively (P being the period).
- R5: With `mod_en` at 1 and no brownout, a low data level makes `tx_pin` follow the carrier (low in the low window, high otherwise). A high data level holds `tx_pin` high with no carrier.
- R6: While `brownout` is 1, modulation is suppressed and `tx_pin` follows the data level one clock later, even with `mod_en` set.
- R7: With `rx_dis` at 0, `uart_rxd` equals `rx_pin` XOR `rx_inv`, delayed by SYNC_STAGES+1 clocks, and `gpi_bit` is held at 0.
- R8: With `rx_dis` at 1, `uart_rxd` is held at 1 and `gpi_bit` carries the synchronised, non-inverted `rx_pin`.
- R9: During and directly after synchronous reset, `tx_pin` is 1, `uart_rxd` is 1 and `gpi_bit` is 0. The synchroniser stages reset to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_sel | input | 2 | Transmit source select |
| tx_inv | input | 1 | Invert the selected transmit source |
| mod_en | input | 1 | Enable carrier modulation |
| duty_sel | input | 2 | Carrier low-time select |
| brownout | input | 1 | System power absent; suppresses modulation |
| uart_txd | input | 1 | Serial transmit data from the UART |
| gpo_bit | input | 1 | General-purpose output level |
| wh_pulse | input | 1 | Active-energy pulse |
| varh_pulse | input | 1 | Reactive-energy pulse |
| tx_pin | output | 1 | Optical transmit pin drive (registered) |
| rx_pin | input | 1 | Optical receive pin (asynchronous) |
| rx_inv | input | 1 | Invert the receive path toward the UART |
| rx_dis | input | 1 | Release the receive pin as general-purpose input |
| uart_rxd | output | 1 | Receive data to the UART (registered) |
| gpi_bit | output | 1 | General-purpose input level (registered) |

## Verification
The bench drives every source and duty code against a behavioural model and counts low cycles over whole carrier periods. An off-by-one shift or a swapped duty code therefore shows up as a wrong low count. It also measures the distance between carrier falling edges, which catches a counter that wraps one cycle late or restarts on the wrong phase. Idle-high data with modulation on exposes a design that gates the carrier regardless of data level. Brownout with low data exposes one that keeps modulating. Inversion applied after the carrier, or an inverted general-purpose input, shows up as mismatches against the model on every affected clock.

// File: rtl/optx_pkg.sv
package optx_pkg;

  typedef enum logic [1:0] {
    TXSRC_UART = 2'd0,
    TXSRC_GPO  = 2'd1,
    TXSRC_WH   = 2'd2,
    TXSRC_VARH = 2'd3
  } tx_src_e;

  typedef enum logic [1:0] {
    DUTY_1_16 = 2'd0,
    DUTY_1_2  = 2'd1,
    DUTY_1_4  = 2'd2,
    DUTY_1_8  = 2'd3
  } duty_e;

  // Nearest whole number of clocks per carrier period.
  function automatic int unsigned carrier_period(input int unsigned clk_hz,
                                                 input int unsigned car_hz);
    return (clk_hz + car_hz / 2) / car_hz;
  endfunction

endpackage

// File: rtl/optx_carrier.sv
module optx_carrier
  import optx_pkg::*;
#(
  parameter int unsigned PERIOD = 3289
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] duty_sel,
  output logic       car_low
);

  localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
  localparam logic [CW-1:0] LOW2  = CW'(PERIOD >> 1);
  localparam logic [CW-1:0] LOW4  = CW'(PERIOD >> 2);
  localparam logic [CW-1:0] LOW8  = CW'(PERIOD >> 3);
  localparam logic [CW-1:0] LOW16 = CW'(PERIOD >> 4);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] low_len;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    unique case (duty_e'(duty_sel))
      DUTY_1_2:  low_len = LOW2;
      DUTY_1_4:  low_len = LOW4;
      DUTY_1_8:  low_len = LOW8;
      default:   low_len = LOW16;
    endcase
  end

  assign car_low = (cnt_q < low_len);

  p_cnt_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q == LAST |=> cnt_q == '0);

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q != LAST |=> cnt_q == $past(cnt_q) + 1'b1);

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  p_low_at_start_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q == '0 |-> car_low);

endmodule

// File: rtl/optx_tx_path.sv
module optx_tx_path
  import optx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] tx_sel,
  input  logic       tx_inv,
  input  logic       mod_en,
  input  logic       brownout,
  input  logic [3:0] src,
  input  logic       car_low,
  output logic       tx_pin
);

  logic sel_raw;
  logic data_lvl;
  logic gate_on;
  logic tx_d;
  logic tx_q;

  always_comb begin
    unique case (tx_src_e'(tx_sel))
      TXSRC_UART: sel_raw = src[0];
      TXSRC_GPO:  sel_raw = src[1];
      TXSRC_WH:   sel_raw = src[2];
      default:    sel_raw = src[3];
    endcase
  end

  // Polarity first, so the active-low test sees the post-inversion level.
  assign data_lvl = sel_raw ^ tx_inv;
  assign gate_on  = mod_en & ~brownout & ~data_lvl;
  assign tx_d     = gate_on ? ~car_low : data_lvl;

  always_ff @(posedge clk) begin
    if (rst) tx_q <= 1'b1;
    else     tx_q <= tx_d;
  end

  assign tx_pin = tx_q;

  p_idle_no_carrier_r5: assert property (@(posedge clk) disable iff (rst)
    (mod_en && data_lvl) |=> tx_pin);

  p_brownout_plain_r6: assert property (@(posedge clk) disable iff (rst)
    brownout |=> tx_pin == $past(data_lvl));

  p_plain_follow_r1: assert property (@(posedge clk) disable iff (rst)
    !mod_en |=> tx_pin == $past(data_lvl));

endmodule

// File: rtl/optx_rx_path.sv
module optx_rx_path #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_pin,
  input  logic rx_inv,
  input  logic rx_dis,
  output logic uart_rxd,
  output logic gpi_bit
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  logic                   urx_q;
  logic                   gpi_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= rx_pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rx_pin};
      end
    end
  endgenerate

  assign rx_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      urx_q <= 1'b1;
      gpi_q <= 1'b0;
    end else if (rx_dis) begin
      urx_q <= 1'b1;
      gpi_q <= rx_s;
    end else begin
      urx_q <= rx_s ^ rx_inv;
      gpi_q <= 1'b0;
    end
  end

  assign uart_rxd = urx_q;
  assign gpi_bit  = gpi_q;

  p_rx_dis_idle_r8: assert property (@(posedge clk) disable iff (rst)
    rx_dis |=> uart_rxd);

  p_gpi_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !rx_dis |=> !gpi_bit);

endmodule

// File: rtl/optx_port.sv
module optx_port
  import optx_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 125_000_000,
  parameter int unsigned CARRIER_HZ  = 38_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] tx_sel,
  input  logic       tx_inv,
  input  logic       mod_en,
  input  logic [1:0] duty_sel,
  input  logic       brownout,
  input  logic       uart_txd,
  input  logic       gpo_bit,
  input  logic       wh_pulse,
  input  logic       varh_pulse,
  output logic       tx_pin,
  input  logic       rx_pin,
  input  logic       rx_inv,
  input  logic       rx_dis,
  output logic       uart_rxd,
  output logic       gpi_bit
);

  localparam int unsigned PERIOD = carrier_period(CLK_HZ, CARRIER_HZ);

  logic       car_low;
  logic [3:0] src;

  assign src = {varh_pulse, wh_pulse, gpo_bit, uart_txd};

  optx_carrier #(.PERIOD(PERIOD)) u_carrier (
    .clk      (clk),
    .rst      (rst),
    .duty_sel (duty_sel),
    .car_low  (car_low)
  );

  optx_tx_path u_tx (
    .clk      (clk),
    .rst      (rst),
    .tx_sel   (tx_sel),
    .tx_inv   (tx_inv),
    .mod_en   (mod_en),
    .brownout (brownout),
    .src      (src),
    .car_low  (car_low),
    .tx_pin   (tx_pin)
  );

  optx_rx_path #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .rx_pin   (rx_pin),
    .rx_inv   (rx_inv),
    .rx_dis   (rx_dis),
    .uart_rxd (uart_rxd),
    .gpi_bit  (gpi_bit)
  );

  p_reset_levels_r9: assert property (@(posedge clk)
    rst |=> (tx_pin && uart_rxd && !gpi_bit));

endmodule

// File: tb/optx_port_bench.sv
module optx_port_bench;

  localparam int CLK_HZ = 3_800_000;
  localparam int P      = 100;
  localparam int SYNC   = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1;
  logic [1:0] tx_sel = 2'd0;
  logic       tx_inv = 1'b0, mod_en = 1'b0, brownout = 1'b0;
  logic [1:0] duty_sel = 2'd1;
  logic       uart_txd = 1'b1, gpo_bit = 1'b1, wh_pulse = 1'b1, varh_pulse = 1'b1;
  logic       rx_pin = 1'b1, rx_inv = 1'b0, rx_dis = 1'b0;
  logic       tx_pin, uart_rxd, gpi_bit;

  optx_port #(.CLK_HZ(CLK_HZ), .SYNC_STAGES(SYNC)) u_optx_port (
    .clk(clk), .rst(rst), .tx_sel(tx_sel), .tx_inv(tx_inv), .mod_en(mod_en),
    .duty_sel(duty_sel), .brownout(brownout), .uart_txd(uart_txd),
    .gpo_bit(gpo_bit), .wh_pulse(wh_pulse), .varh_pulse(varh_pulse),
    .tx_pin(tx_pin), .rx_pin(rx_pin), .rx_inv(rx_inv), .rx_dis(rx_dis),
    .uart_rxd(uart_rxd), .gpi_bit(gpi_bit)
  );

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string req = "R9";
  bit    done = 1'b0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // Behavioural reference model, updated at every rising edge.
  int   phase, ll;
  logic m_d, e_tx, e_urx, e_gpi, m_s;
  logic hist[$];

  always @(posedge clk) begin
    if (rst) begin
      phase = 0; e_tx = 1'b1; e_urx = 1'b1; e_gpi = 1'b0;
      hist = {};
      for (int i = 0; i < SYNC; i++) hist.push_back(1'b1);
    end else begin
      case (tx_sel)
        2'd0: m_d = uart_txd;
        2'd1: m_d = gpo_bit;
        2'd2: m_d = wh_pulse;
        default: m_d = varh_pulse;
      endcase
      m_d = m_d ^ tx_inv;
      case (duty_sel)
        2'd1: ll = P / 2;
        2'd2: ll = P / 4;
        2'd3: ll = P / 8;
        default: ll = P / 16;
      endcase
      e_tx  = (mod_en && !brownout && !m_d) ? !(phase < ll) : m_d;
      phase = (phase + 1) % P;
      m_s   = hist[0];
      if (rx_dis) begin e_urx = 1'b1; e_gpi = m_s; end
      else        begin e_urx = m_s ^ rx_inv; e_gpi = 1'b0; end
      void'(hist.pop_front());
      hist.push_back(rx_pin);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk({req, " tx_pin"},   tx_pin,   e_tx);
      chk({req, " uart_rxd"}, uart_rxd, e_urx);
      chk({req, " gpi_bit"},  gpi_bit,  e_gpi);
    end
  end

  task automatic summary();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      summary();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_low(string r, int expect_lows);
    int lows = 0;
    step(2);
    for (int i = 0; i < P; i++) begin
      step(1);
      if (tx_pin == 1'b0) lows++;
    end
    chk(r, lows, expect_lows);
  endtask

  initial begin
    step(3);
    req = "R9";
    chk("R9 reset tx_pin", tx_pin, 1'b1);
    chk("R9 reset uart_rxd", uart_rxd, 1'b1);
    chk("R9 reset gpi_bit", gpi_bit, 1'b0);
    rst = 1'b0;

    // R1: source select, modulation off
    req = "R1";
    for (int s = 0; s < 4; s++) begin
      tx_sel = 2'(s);
      for (int k = 0; k < 12; k++) begin
        uart_txd = k[0]; gpo_bit = k[1]; wh_pulse = k[2]; varh_pulse = ~k[0];
        step(1);
      end
    end
    tx_sel = 2'd2; wh_pulse = 1'b0; gpo_bit = 1'b1; step(2);
    chk("R1 energy pulse routed", tx_pin, 1'b0);

    // R2: inversion ahead of modulation
    req = "R2"; tx_inv = 1'b1;
    for (int k = 0; k < 10; k++) begin tx_sel = 2'(k % 4); wh_pulse = k[0]; step(1); end
    tx_sel = 2'd1; gpo_bit = 1'b1; mod_en = 1'b1; duty_sel = 2'd1;
    count_low("R2 inverted high modulates", P / 2);
    tx_inv = 1'b0; mod_en = 1'b0; step(2);

    // R4: low count per duty code, data low on UART source
    req = "R4"; tx_sel = 2'd0; uart_txd = 1'b0; mod_en = 1'b1;
    duty_sel = 2'd1; count_low("R4 duty code 1", P / 2);
    duty_sel = 2'd2; count_low("R4 duty code 2", P / 4);
    duty_sel = 2'd3; count_low("R4 duty code 3", P / 8);
    duty_sel = 2'd0; count_low("R4 duty code 0", P / 16);

    // R3: period between carrier falling edges
    req = "R3"; duty_sel = 2'd1; step(2);
    begin
      logic prev; int gap;
      prev = tx_pin;
      while (!(prev == 1'b1 && tx_pin == 1'b0)) begin prev = tx_pin; step(1); end
      gap = 0; prev = tx_pin;
      do begin prev = tx_pin; step(1); gap++; end
      while (!(prev == 1'b1 && tx_pin == 1'b0));
      chk("R3 carrier period", gap, P);
    end

    // R5: idle-high data carries no carrier
    req = "R5"; uart_txd = 1'b1;
    count_low("R5 idle data no carrier", 0);
    for (int k = 0; k < 3 * P; k++) begin uart_txd = (k % 37) < 20; step(1); end

    // R6: brownout removes carrier
    req = "R6"; brownout = 1'b1; uart_txd = 1'b0;
    count_low("R6 brownout follows data", P);
    brownout = 1'b0; mod_en = 1'b0; uart_txd = 1'b1; step(2);

    // R7: receive path with inversion
    req = "R7"; rx_dis = 1'b0;
    for (int k = 0; k < 40; k++) begin rx_inv = k > 19; rx_pin = (k % 5) < 2; step(1); end
    rx_inv = 1'b1; rx_pin = 1'b1; step(SYNC + 2);
    chk("R7 inverted receive", uart_rxd, 1'b0);
    chk("R7 gpi quiet", gpi_bit, 1'b0);

    // R8: receive disabled, pin to general-purpose input
    req = "R8"; rx_dis = 1'b1;
    for (int k = 0; k < 40; k++) begin rx_pin = (k % 7) < 3; step(1); end
    rx_pin = 1'b0; step(SYNC + 2);
    chk("R8 uart idle", uart_rxd, 1'b1);
    chk("R8 gpi not inverted", gpi_bit, 1'b0);
    rx_dis = 1'b0; rx_inv = 1'b0; step(4);

    // R9: reset in mid-run restores levels
    req = "R9"; mod_en = 1'b1; uart_txd = 1'b0; rst = 1'b1; step(2);
    chk("R9 re-reset tx_pin", tx_pin, 1'b1);
    rst = 1'b0; duty_sel = 2'd2;
    count_low("R9 phase restarts", P / 4);

    summary();
  end

endmodule